// File: doc/BRIEF.md
# Execution Trace Capture Buffer

This block sits beside a small 4-bit CPU core and keeps a per-cycle history of what the core did. Each CPU cycle whose execution address lies inside a programmable window is turned into one record. A record holds the fetch address and opcode, the four 4-bit working registers and four flags as they stand after the cycle, a data-access descriptor, a stack-select code and the level of an external trace-in pin. Records go into an on-chip circular memory. The deployed configuration holds 8192 records, set through the `DEPTH_LOG2` parameter.

Two capture modes exist. In wrap mode the newest record always replaces the oldest once the memory is full. In delayed-trigger mode the memory is never overwritten. A trigger starts a countdown of post-trigger records, and capture freezes when that countdown ends or when the memory fills, whichever comes first. A pulse on the run-start input empties the buffer at the start of every program run.

A debug host reads the history back by relative index. Index 1 is the most recent record, and larger indices reach further into the past.

Top module: `xtrc_capture`

## Requirements
- R1: The memory holds 2**DEPTH_LOG2 records. The `fill` output counts stored records and saturates at 2**DEPTH_LOG2.
- R2: In wrap mode (`delay_mode`=0), a capture into a full memory replaces the oldest record, so the buffer keeps the newest 2**DEPTH_LOG2 records. `trig` has no effect in this mode.
- R3: In delayed-trigger mode (`delay_mode`=1), once `fill` equals capacity no further record is written, nothing is overwritten, and `frozen` is 1.
- R4: In delayed-trigger mode, the first captured cycle with `trig`=1 is recorded, and then exactly `post_cycles` further records are captured. After that `frozen` is 1 and later cycles are ignored until run-start. With `post_cycles`=0 the trigger record is the last one.
- R5: `run_start`=1 empties the buffer on that clock edge. `fill` becomes 0, the trigger state returns to idle and `frozen` becomes 0. A cycle presented together with `run_start` is not recorded. After reset, `fill`=0, `frozen`=0 and `rd_valid`=0.
- R6: A cycle is recorded only when `cyc_valid`=1 and `win_lo` <= `exec_addr` <= `win_hi` (unsigned, inclusive).
- R7: A read with `rd_en`=1 returns its result one clock later on `rd_valid`/`rd_rec`. Index 1 is the newest record and index k is the k-th newest. `rd_valid` is 1 only for 1 <= `rd_idx` <= `fill`. For any other index `rd_valid` is 0 and `rd_rec` is all zeros.
- R8: A read issued in the same cycle as a capture write is resolved against the buffer as it was before that write.
- R9: The record layout, MSB first, is: fetch_addr[15:0], fetch_code[12:0], reg_a, reg_b, reg_x, reg_y (4 bits each), flags[3:0] (E,I,C,Z from bit 3 down), dacc_addr[15:0], dacc_write, dacc_wide, dacc_data[15:0], stack_sel[1:0], trace_low. The total is 86 bits.
- R10: For a 4-bit access (`dacc_wide`=0), bits 15:4 of the stored data are zero and bits 3:0 are the input nibble. `trace_low` stores 1 when `trace_pin` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Clears the buffer at program run start |
| cyc_valid | input | 1 | A CPU cycle completes this clock |
| exec_addr | input | 16 | Execution address used for window qualification |
| win_lo | input | 16 | Lower window bound, inclusive |
| win_hi | input | 16 | Upper window bound, inclusive |
| delay_mode | input | 1 | 0 wrap mode, 1 delayed-trigger mode |
| trig | input | 1 | Trigger request |
| post_cycles | input | PC_W | Records captured after the trigger record |
| fetch_addr | input | 16 | Fetch address |
| fetch_code | input | 13 | Fetch opcode |
| reg_a | input | 4 | Register A after the cycle |
| reg_b | input | 4 | Register B after the cycle |
| reg_x | input | 4 | Register X after the cycle |
| reg_y | input | 4 | Register Y after the cycle |
| flags | input | 4 | E,I,C,Z flags after the cycle |
| dacc_addr | input | 16 | Data access address |
| dacc_write | input | 1 | 1 write, 0 read |
| dacc_wide | input | 1 | 1 for a 16-bit access, 0 for a 4-bit access |
| dacc_data | input | 16 | Data accessed |
| stack_sel | input | 2 | Stack access code (0 none, 1 first stack, 2 second stack) |
| trace_pin | input | 1 | External trace-in pin level |
| rd_en | input | 1 | Read request |
| rd_idx | input | DEPTH_LOG2+1 | Relative read index, 1 for the newest record |
| rd_valid | output | 1 | Read result valid |
| rd_rec | output | 86 | Read record |
| fill | output | DEPTH_LOG2+1 | Number of stored records |
| frozen | output | 1 | Capture stopped |

## Verification
The bench builds the block with `DEPTH_LOG2`=4 (16 records) and `PC_W`=8. With these values, wrap-around, the full stop in delayed-trigger mode and the trigger countdown all occur within a few dozen cycles. Every relative index from 0 to two past capacity is swept after each scenario. A separate reference history computes the expected records, fill and freeze state for every cycle, including reads that coincide with captures and a window that cuts off part of an address ramp.

// File: rtl/xtrc_pkg.sv
package xtrc_pkg;

    localparam int FA_W = 16;
    localparam int FC_W = 13;
    localparam int RG_W = 4;
    localparam int DA_W = 16;
    localparam int DD_W = 16;
    localparam int NIB_W = 4;

    typedef struct packed {
        logic [FA_W-1:0] fetch_addr;
        logic [FC_W-1:0] fetch_code;
        logic [RG_W-1:0] reg_a;
        logic [RG_W-1:0] reg_b;
        logic [RG_W-1:0] reg_x;
        logic [RG_W-1:0] reg_y;
        logic [3:0]      flags;
        logic [DA_W-1:0] dacc_addr;
        logic            dacc_write;
        logic            dacc_wide;
        logic [DD_W-1:0] dacc_data;
        logic [1:0]      stack_sel;
        logic            trace_low;
    } trace_rec_t;

    localparam int REC_W = $bits(trace_rec_t);

    typedef enum logic [1:0] {
        TS_IDLE   = 2'd0,
        TS_ARMED  = 2'd1,
        TS_FROZEN = 2'd2
    } trig_state_e;

    function automatic logic in_window(input logic [FA_W-1:0] a,
                                       input logic [FA_W-1:0] lo,
                                       input logic [FA_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic [DD_W-1:0] fit_data(input logic wide,
                                                 input logic [DD_W-1:0] d);
        return wide ? d : {{(DD_W-NIB_W){1'b0}}, d[NIB_W-1:0]};
    endfunction

endpackage

// File: rtl/xtrc_window.sv
module xtrc_window
    import xtrc_pkg::*;
(
    input  logic            cyc_valid,
    input  logic [FA_W-1:0] exec_addr,
    input  logic [FA_W-1:0] win_lo,
    input  logic [FA_W-1:0] win_hi,
    output logic            hit
);
    always_comb begin
        hit = cyc_valid && in_window(exec_addr, win_lo, win_hi);
    end
endmodule

// File: rtl/xtrc_trig_ctrl.sv
module xtrc_trig_ctrl
    import xtrc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            delay_mode,
    input  logic            trig,
    input  logic [PC_W-1:0] post_cycles,
    input  logic            cap,
    output logic            stopped
);
    trig_state_e     st_q;
    logic [PC_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q     <= TS_IDLE;
            remain_q <= '0;
        end else if (cap && delay_mode) begin
            unique case (st_q)
                TS_IDLE: begin
                    if (trig) begin
                        remain_q <= post_cycles;
                        st_q     <= (post_cycles == '0) ? TS_FROZEN : TS_ARMED;
                    end
                end
                TS_ARMED: begin
                    if (remain_q == PC_W'(1)) begin
                        st_q <= TS_FROZEN;
                    end
                    remain_q <= remain_q - PC_W'(1);
                end
                default: st_q <= st_q;
            endcase
        end
    end

    assign stopped = (st_q == TS_FROZEN);

    a_r4_stays_frozen: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_FROZEN && !clr) |=> (st_q == TS_FROZEN));

    a_r4_armed_nonzero: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_ARMED) |-> (remain_q != '0));

    a_r5_clear_idle: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st_q == TS_IDLE));
endmodule

// File: rtl/xtrc_ring.sv
module xtrc_ring
    import xtrc_pkg::*;
#(
    parameter int DEPTH_LOG2 = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic [REC_W-1:0]      wr_rec,
    input  logic                  rd_en,
    input  logic [DEPTH_LOG2:0]   rd_idx,
    output logic                  rd_valid,
    output logic [REC_W-1:0]      rd_rec,
    output logic [DEPTH_LOG2:0]   fill,
    output logic                  full
);
    localparam int L = DEPTH_LOG2;
    localparam int DEPTH = 1 << L;
    localparam logic [L:0] FULL_CNT = {1'b1, {L{1'b0}}};

    logic [REC_W-1:0] mem [DEPTH];
    logic [L-1:0]     wr_ptr_q;
    logic [L:0]       fill_q;
    logic [L-1:0]     rd_addr;
    logic             rd_hit;

    assign full    = (fill_q == FULL_CNT);
    assign fill    = fill_q;
    assign rd_addr = wr_ptr_q - rd_idx[L-1:0];
    assign rd_hit  = rd_en && (rd_idx != '0) && (rd_idx <= fill_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr_q <= '0;
            fill_q   <= '0;
        end else if (wr_en) begin
            wr_ptr_q <= wr_ptr_q + L'(1);
            if (!full) begin
                fill_q <= fill_q + (L+1)'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            mem[wr_ptr_q] <= wr_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_rec   <= '0;
        end else begin
            rd_valid <= rd_hit;
            rd_rec   <= rd_hit ? mem[rd_addr] : '0;
        end
    end

    a_r1_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FULL_CNT);

    a_r1_fill_step: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full && !clr) |=> (fill_q == $past(fill_q) + (L+1)'(1)));

    a_r5_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (fill_q == '0));

    a_r7_zero_idx_invalid: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_idx == '0) |=> !rd_valid);
endmodule

// File: rtl/xtrc_capture.sv
module xtrc_capture
    import xtrc_pkg::*;
#(
    parameter int DEPTH_LOG2 = 11,
    parameter int PC_W       = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_start,
    input  logic                  cyc_valid,
    input  logic [15:0]           exec_addr,
    input  logic [15:0]           win_lo,
    input  logic [15:0]           win_hi,
    input  logic                  delay_mode,
    input  logic                  trig,
    input  logic [PC_W-1:0]       post_cycles,
    input  logic [15:0]           fetch_addr,
    input  logic [12:0]           fetch_code,
    input  logic [3:0]            reg_a,
    input  logic [3:0]            reg_b,
    input  logic [3:0]            reg_x,
    input  logic [3:0]            reg_y,
    input  logic [3:0]            flags,
    input  logic [15:0]           dacc_addr,
    input  logic                  dacc_write,
    input  logic                  dacc_wide,
    input  logic [15:0]           dacc_data,
    input  logic [1:0]            stack_sel,
    input  logic                  trace_pin,
    input  logic                  rd_en,
    input  logic [DEPTH_LOG2:0]   rd_idx,
    output logic                  rd_valid,
    output logic [85:0]           rd_rec,
    output logic [DEPTH_LOG2:0]   fill,
    output logic                  frozen
);
    logic       hit;
    logic       stopped;
    logic       full;
    logic       cap_we;
    trace_rec_t rec;

    xtrc_window u_window (
        .cyc_valid (cyc_valid),
        .exec_addr (exec_addr),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .hit       (hit)
    );

    xtrc_trig_ctrl #(.PC_W(PC_W)) u_trig (
        .clk         (clk),
        .rst         (rst),
        .clr         (run_start),
        .delay_mode  (delay_mode),
        .trig        (trig),
        .post_cycles (post_cycles),
        .cap         (cap_we),
        .stopped     (stopped)
    );

    always_comb begin
        rec.fetch_addr = fetch_addr;
        rec.fetch_code = fetch_code;
        rec.reg_a      = reg_a;
        rec.reg_b      = reg_b;
        rec.reg_x      = reg_x;
        rec.reg_y      = reg_y;
        rec.flags      = flags;
        rec.dacc_addr  = dacc_addr;
        rec.dacc_write = dacc_write;
        rec.dacc_wide  = dacc_wide;
        rec.dacc_data  = fit_data(dacc_wide, dacc_data);
        rec.stack_sel  = stack_sel;
        rec.trace_low  = ~trace_pin;
    end

    assign frozen = stopped || (delay_mode && full);
    assign cap_we = hit && !run_start && !frozen;

    xtrc_ring #(.DEPTH_LOG2(DEPTH_LOG2)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .clr      (run_start),
        .wr_en    (cap_we),
        .wr_rec   (rec),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_rec   (rd_rec),
        .fill     (fill),
        .full     (full)
    );

    a_r3_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        (delay_mode && full) |-> !cap_we);

    a_r6_window_only: assert property (@(posedge clk) disable iff (rst)
        cap_we |-> (cyc_valid && exec_addr >= win_lo && exec_addr <= win_hi));

    a_r5_start_blocks: assert property (@(posedge clk) disable iff (rst)
        run_start |-> !cap_we);
endmodule

// File: tb/xtrc_capture_tb_top.sv
module xtrc_capture_tb_top;
    localparam int DL = 4;
    localparam int D  = 1 << DL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic run_start = 0, cyc_valid = 0, delay_mode = 0, trig = 0;
    logic [15:0] exec_addr = 0, win_lo = 0, win_hi = 16'hFFFF;
    logic [7:0]  post_cycles = 0;
    logic [15:0] fetch_addr = 0, dacc_addr = 0, dacc_data = 0;
    logic [12:0] fetch_code = 0;
    logic [3:0]  reg_a = 0, reg_b = 0, reg_x = 0, reg_y = 0, flags = 0;
    logic        dacc_write = 0, dacc_wide = 0, trace_pin = 1;
    logic [1:0]  stack_sel = 0;
    logic        rd_en = 0;
    logic [DL:0] rd_idx = 0;
    logic        rd_valid, frozen;
    logic [85:0] rd_rec;
    logic [DL:0] fill;

    xtrc_capture #(.DEPTH_LOG2(DL), .PC_W(8)) dut_i (
        .clk(clk), .rst(rst), .run_start(run_start), .cyc_valid(cyc_valid),
        .exec_addr(exec_addr), .win_lo(win_lo), .win_hi(win_hi),
        .delay_mode(delay_mode), .trig(trig), .post_cycles(post_cycles),
        .fetch_addr(fetch_addr), .fetch_code(fetch_code), .reg_a(reg_a),
        .reg_b(reg_b), .reg_x(reg_x), .reg_y(reg_y), .flags(flags),
        .dacc_addr(dacc_addr), .dacc_write(dacc_write), .dacc_wide(dacc_wide),
        .dacc_data(dacc_data), .stack_sel(stack_sel), .trace_pin(trace_pin),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_rec(rd_rec),
        .fill(fill), .frozen(frozen)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [85:0] hist[$];
    int st_m = 0, rem_m = 0;
    string ftag = "R5";
    string dtag = "R9 R10";

    task automatic chk(input string tag, input logic [85:0] act, input logic [85:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected record, packed per R9 with the R10 masking and pin inversion
    function automatic logic [85:0] mk(input int n, input logic [15:0] a);
        logic [15:0] d = 16'(n * 16'h1357);
        logic        w = n[0];
        logic [15:0] dm = w ? d : {12'h000, d[3:0]};
        return {a, 13'(n * 5), n[3:0], ~n[3:0], n[5:2], n[7:4], n[3:0] ^ 4'hA,
                16'(n * 33), n[2], w, dm, 2'(n % 3), ~n[1]};
    endfunction

    task automatic cyc(input logic v, input logic [15:0] a, input int n,
                       input logic tg, input logic run, input logic rd, input int idx);
        logic        ev;
        logic [85:0] ed;
        logic        fz;
        logic        q;
        cyc_valid = v; exec_addr = a; fetch_addr = a; trig = tg; run_start = run;
        fetch_code = 13'(n * 5); reg_a = n[3:0]; reg_b = ~n[3:0]; reg_x = n[5:2];
        reg_y = n[7:4]; flags = n[3:0] ^ 4'hA; dacc_addr = 16'(n * 33);
        dacc_write = n[2]; dacc_wide = n[0]; dacc_data = 16'(n * 16'h1357);
        stack_sel = 2'(n % 3); trace_pin = n[1];
        rd_en = rd; rd_idx = (DL+1)'(idx);
        @(posedge clk);
        ev = rd && idx != 0 && idx <= hist.size();
        ed = ev ? hist[hist.size() - idx] : 86'd0;
        fz = (st_m == 2) || (delay_mode && hist.size() == D);
        q  = v && a >= win_lo && a <= win_hi;
        if (run) begin
            hist.delete(); st_m = 0; rem_m = 0;
        end else if (q && !fz) begin
            hist.push_back(mk(n, a));
            if (hist.size() > D) void'(hist.pop_front());
            if (delay_mode) begin
                if (st_m == 0 && tg) begin
                    rem_m = post_cycles; st_m = (post_cycles == 0) ? 2 : 1;
                end else if (st_m == 1) begin
                    if (rem_m == 1) st_m = 2;
                    rem_m--;
                end
            end
        end
        @(negedge clk);
        chk("R7", {85'd0, rd_valid}, {85'd0, ev});
        chk(dtag, rd_rec, ed);
        chk(ftag, {81'd0, fill}, 86'(hist.size()));
        chk(ftag, {85'd0, frozen}, {85'd0, (st_m == 2) || (delay_mode && hist.size() == D)});
    endtask

    task automatic sweep();
        for (int k = 0; k <= D + 2; k++) cyc(0, 16'h0, 0, 0, 0, 1, k);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R5", {81'd0, fill}, 86'd0);
        chk("R5", {85'd0, frozen}, 86'd0);
        chk("R5", {85'd0, rd_valid}, 86'd0);
        sweep();

        // R2 R6 R8: wrap mode, address ramp across a window, reads during writes, trig ignored
        ftag = "R1 R2 R6"; dtag = "R8 R9 R10";
        delay_mode = 0; win_lo = 16'h0040; win_hi = 16'h005F;
        for (int n = 0; n < 60; n++) cyc(1, 16'(16'h30 + n), n, n[3], 0, 1, n % 19);
        dtag = "R2 R9 R10";
        sweep();

        // R5: run start with a qualifying cycle records nothing
        ftag = "R5";
        cyc(1, 16'h0045, 7, 0, 1, 1, 1);
        sweep();

        // R4: delayed trigger with post count 3
        ftag = "R4"; dtag = "R4 R9 R10";
        delay_mode = 1; win_lo = 16'h0000; win_hi = 16'hFFFF; post_cycles = 3;
        for (int n = 100; n < 116; n++) cyc(1, 16'(16'h200 + n), n, n == 105, 0, 1, 1);
        sweep();

        // R3: delayed mode without trigger stops when full
        ftag = "R3"; dtag = "R3 R9";
        cyc(0, 0, 0, 0, 1, 0, 0);
        for (int n = 200; n < 224; n++) cyc(1, 16'(16'h300 + n), n, 0, 0, 1, 2);
        sweep();

        // R4: post count zero freezes on the trigger record
        ftag = "R4"; dtag = "R4 R10";
        post_cycles = 0;
        cyc(0, 0, 0, 0, 1, 0, 0);
        for (int n = 40; n < 48; n++) cyc(1, 16'(16'h100 + n), n, n == 42, 0, 1, 1);
        sweep();

        // R7: index above fill and zero after partial fill in wrap mode
        ftag = "R7"; dtag = "R7";
        delay_mode = 0;
        cyc(0, 0, 0, 0, 1, 0, 0);
        for (int n = 8; n < 13; n++) cyc(1, 16'h0010, n, 0, 0, 1, 0);
        sweep();

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule